// File: doc/BRIEF.md
# Mode-Banked Integer Register File

This block holds the integer operand storage of a 64-bit core: 32 architectural registers, two combinational read ports and one write port. Alongside the architectural array sits a bank of eight shadow registers. A privileged-mode input from the core decides whether the shadow bank is in use. While the input is high, a fixed and non-contiguous group of register numbers is steered to the shadow bank. All other register numbers still reach the architectural array.

Privileged handler code can therefore use a private working set without saving and restoring the registers of the interrupted program. Once the mode input drops, the program sees its own values again, and the shadow bank keeps its contents for the next privileged entry. Register 31 is a hardwired zero. A read that coincides with a write to the same resolved location returns the value being written.

Top module: `shadow_regfile`

## Requirements
- R1: While rst_ni is low, every architectural and every shadow entry is cleared, so after reset every index reads 0 in either mode.
- R2: With pal_mode_i low, a write to index i (i from 0 to 30) is returned by later reads of index i in the same mode.
- R3: With pal_mode_i high, indices 8 to 14 access shadow entries 0 to 6 in order. A write made in this mode does not change what the same index reads once pal_mode_i is low.
- R4: With pal_mode_i high, index 25 accesses shadow entry 7, which is distinct from the architectural register 25.
- R5: With pal_mode_i high, every index other than 8 to 14, 25 and 31 accesses the same architectural register that it accesses with pal_mode_i low.
- R6: With pal_mode_i low, writes never change the shadow entries. Values written to indices 8 to 14 and 25 in privileged mode read back unchanged on the next privileged entry.
- R7: Index 31 reads 0 on both ports in both modes, and a write to index 31 is discarded.
- R8: When we_i is high and a read index resolves to the same location as wa_addr_i, that read port returns wd_i in the same cycle.
- R9: The two read ports are independent: each returns the value at its own index, whichever index the other port presents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pal_mode_i | input | 1 | Privileged mode; enables shadow steering |
| ra_addr_i | input | 5 | Read port A index |
| ra_data_o | output | 64 | Read port A data |
| rb_addr_i | input | 5 | Read port B index |
| rb_data_o | output | 64 | Read port B data |
| we_i | input | 1 | Write enable |
| wa_addr_i | input | 5 | Write index |
| wd_i | input | 64 | Write data |

## Verification
The bench fills all 32 indices with distinct data in user mode and again in privileged mode. It then reads every index back in both modes on both ports, with port B running in reverse order. A wrong shadow mapping, a lost shadow value or a shadow write leaking into the architectural array therefore shows up as a value tied to the wrong index and mode. Writes are issued together with a read of the same index, which separates the write-first bypass from the registered path. A final pseudo-random phase mixes modes, indices and data. A second reset checks that both banks are cleared.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_AW    = 5;
  localparam int unsigned ZERO_IDX = 31;
  localparam int unsigned SH_LO    = 8;
  localparam int unsigned SH_HI    = 14;
  localparam int unsigned SH_ALT   = 25;
  localparam int unsigned SH_N     = SH_HI - SH_LO + 2;
  localparam int unsigned SH_AW    = $clog2(SH_N);

  typedef struct packed {
    logic             zero;
    logic             shadow;
    logic [RF_AW-1:0] idx;
  } rf_loc_t;
endpackage

// File: rtl/rf_remap.sv
module rf_remap
  import rf_pkg::*;
(
  input  logic             pal_i,
  input  logic [RF_AW-1:0] addr_i,
  output rf_loc_t          loc_o
);
  always_comb begin
    loc_o.zero   = (addr_i == RF_AW'(ZERO_IDX));
    loc_o.shadow = 1'b0;
    loc_o.idx    = addr_i;
    if (pal_i && !loc_o.zero) begin
      if (addr_i >= RF_AW'(SH_LO) && addr_i <= RF_AW'(SH_HI)) begin
        loc_o.shadow = 1'b1;
        loc_o.idx    = addr_i - RF_AW'(SH_LO);
      end else if (addr_i == RF_AW'(SH_ALT)) begin
        loc_o.shadow = 1'b1;
        loc_o.idx    = RF_AW'(SH_N - 1);
      end
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned XLEN  = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  output logic [XLEN-1:0] ra_o,
  output logic [XLEN-1:0] rb_o
);
  logic [XLEN-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign ra_o = mem_q[ra_i];
  assign rb_o = mem_q[rb_i];
endmodule

// File: rtl/rf_rport.sv
module rf_rport
  import rf_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  rf_loc_t         rloc_i,
  input  rf_loc_t         wloc_i,
  input  logic            wen_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] arch_i,
  input  logic [XLEN-1:0] shadow_i,
  output logic [XLEN-1:0] data_o
);
  // write-first: same resolved location (bank + index)
  always_comb begin
    if (rloc_i.zero)                      data_o = '0;
    else if (wen_i && wloc_i == rloc_i)   data_o = wdata_i;
    else if (rloc_i.shadow)               data_o = shadow_i;
    else                                  data_o = arch_i;
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import rf_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREGS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pal_mode_i,
  input  logic [RF_AW-1:0] ra_addr_i,
  output logic [XLEN-1:0]  ra_data_o,
  input  logic [RF_AW-1:0] rb_addr_i,
  output logic [XLEN-1:0]  rb_data_o,
  input  logic             we_i,
  input  logic [RF_AW-1:0] wa_addr_i,
  input  logic [XLEN-1:0]  wd_i
);
  localparam int unsigned NPORT = 3;  // 0: read A, 1: read B, 2: write

  logic [RF_AW-1:0] addr   [NPORT];
  rf_loc_t          loc    [NPORT];
  logic [XLEN-1:0]  arch_d [2];
  logic [XLEN-1:0]  sh_d   [2];
  logic [XLEN-1:0]  rd     [2];
  logic             wen, arch_we, sh_we;

  assign addr[0] = ra_addr_i;
  assign addr[1] = rb_addr_i;
  assign addr[2] = wa_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rf_remap u_map (.pal_i(pal_mode_i), .addr_i(addr[p]), .loc_o(loc[p]));
  end

  assign wen     = we_i && !loc[2].zero;
  assign arch_we = wen && !loc[2].shadow;
  assign sh_we   = wen &&  loc[2].shadow;

  rf_bank #(.DEPTH(NREGS), .XLEN(XLEN)) u_arch (
    .clk_i, .rst_ni,
    .we_i(arch_we), .waddr_i(loc[2].idx), .wdata_i(wd_i),
    .ra_i(loc[0].idx), .rb_i(loc[1].idx),
    .ra_o(arch_d[0]), .rb_o(arch_d[1])
  );

  rf_bank #(.DEPTH(SH_N), .XLEN(XLEN)) u_shadow (
    .clk_i, .rst_ni,
    .we_i(sh_we), .waddr_i(loc[2].idx[SH_AW-1:0]), .wdata_i(wd_i),
    .ra_i(loc[0].idx[SH_AW-1:0]), .rb_i(loc[1].idx[SH_AW-1:0]),
    .ra_o(sh_d[0]), .rb_o(sh_d[1])
  );

  for (genvar r = 0; r < 2; r++) begin : g_rd
    rf_rport #(.XLEN(XLEN)) u_rp (
      .rloc_i(loc[r]), .wloc_i(loc[2]), .wen_i(wen), .wdata_i(wd_i),
      .arch_i(arch_d[r]), .shadow_i(sh_d[r]), .data_o(rd[r])
    );
  end

  assign ra_data_o = rd[0];
  assign rb_data_o = rd[1];

  p_no_shadow_wr_user_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pal_mode_i |-> !sh_we);

  p_shadow_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && pal_mode_i && wa_addr_i >= RF_AW'(SH_LO) && wa_addr_i <= RF_AW'(SH_HI))
    |-> (sh_we && !arch_we));

  p_alt_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && pal_mode_i && wa_addr_i == RF_AW'(SH_ALT)) |-> (sh_we && !arch_we));

  p_zero_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == RF_AW'(ZERO_IDX)) |-> (ra_data_o == '0));

  p_zero_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_addr_i == RF_AW'(ZERO_IDX)) |-> (!arch_we && !sh_we));

  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_addr_i != RF_AW'(ZERO_IDX) && ra_addr_i == wa_addr_i) |-> (ra_data_o == wd_i));

  p_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_addr_i != RF_AW'(ZERO_IDX)) |=>
      (!($stable(pal_mode_i) && ra_addr_i == $past(wa_addr_i)
         && !(we_i && wa_addr_i == ra_addr_i)) || ra_data_o == $past(wd_i)));
endmodule

// File: tb/shadow_regfile_tb_top.sv
module shadow_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pal = 1'b0;
  logic [4:0]  ra = '0, rb = '0, wa = '0;
  logic        we = 1'b0;
  logic [63:0] wd = '0;
  logic [63:0] ra_d, rb_d;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [63:0] arch_m [32];
  logic [63:0] sh_m   [8];

  always #2ns clk = ~clk;

  shadow_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pal_mode_i(pal),
    .ra_addr_i(ra), .ra_data_o(ra_d), .rb_addr_i(rb), .rb_data_o(rb_d),
    .we_i(we), .wa_addr_i(wa), .wd_i(wd)
  );

  // shadow slot per requirements R3/R4, -1 when architectural
  function automatic int sh_slot(bit p, int i);
    if (!p) return -1;
    if (i >= 8 && i <= 14) return i - 8;
    if (i == 25) return 7;
    return -1;
  endfunction

  function automatic logic [63:0] pat(int i, int k);
    return {16'hC3A0 + 16'(k), 16'(i * 97 + k), 16'h5A00 | 16'(i), 16'(k * 31 + i)};
  endfunction

  function automatic logic [63:0] model_rd(bit p, int i);
    int s;
    s = sh_slot(p, i);
    if (i == 31) return '0;
    if (s >= 0) return sh_m[s];
    return arch_m[i];
  endfunction

  function automatic string pick_tag(bit p, bit w, int waddr, int raddr, string base);
    if (raddr == 31) return "R7";
    if (w && waddr == raddr) return "R8";
    return base;
  endfunction

  function automatic string map_tag(bit p, int i, string base);
    if (p && i == 25) return "R4";
    if (sh_slot(p, i) >= 0) return "R3";
    if (p) return "R5";
    return base;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 32; i++) arch_m[i] = '0;
    for (int i = 0; i < 8; i++) sh_m[i] = '0;
  endtask

  task automatic chk(logic [63:0] act, logic [63:0] exp, string tag, string port);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  task automatic cyc(bit p, bit w, int waddr, logic [63:0] wdat,
                     int a, int b, string tag_a, string tag_b);
    logic [63:0] ea, eb;
    @(negedge clk);
    pal = p; we = w; wa = 5'(waddr); wd = wdat; ra = 5'(a); rb = 5'(b);
    #1ns;
    ea = (w && waddr == a && a != 31) ? wdat : model_rd(p, a);
    eb = (w && waddr == b && b != 31) ? wdat : model_rd(p, b);
    chk(ra_d, ea, pick_tag(p, w, waddr, a, tag_a), "A");
    chk(rb_d, eb, pick_tag(p, w, waddr, b, tag_b), "B");
    @(posedge clk);
    if (w && waddr != 31) begin
      if (sh_slot(p, waddr) >= 0) sh_m[sh_slot(p, waddr)] = wdat;
      else arch_m[waddr] = wdat;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sweep_read(bit p, string base);
    for (int i = 0; i < 32; i++)
      cyc(p, 1'b0, 0, '0, i, 31 - i, map_tag(p, i, base), map_tag(p, 31 - i, "R9"));
  endtask

  task automatic sweep_write(bit p, int k, string base);
    for (int i = 0; i < 32; i++)
      cyc(p, 1'b1, i, pat(i, k), i, (i + 1) % 32, base, map_tag(p, (i + 1) % 32, "R9"));
  endtask

  initial begin
    logic [63:0] lfsr;
    clear_model();
    do_reset();
    // R1: both modes read zero after reset
    sweep_read(1'b0, "R1");
    sweep_read(1'b1, "R1");
    // R2: user-mode fill and readback
    sweep_write(1'b0, 1, "R2");
    sweep_read(1'b0, "R2");
    // R3/R4/R5: privileged fill and readback
    sweep_write(1'b1, 2, "R3");
    sweep_read(1'b1, "R3");
    // R3: user view of 8..14 and 25 untouched; R5 shared regs overwritten
    sweep_read(1'b0, "R3");
    // R6: user writes leave shadow bank alone
    sweep_write(1'b0, 3, "R6");
    for (int i = 0; i < 32; i++)
      cyc(1'b1, 1'b0, 0, '0, i, i, (sh_slot(1'b1, i) >= 0) ? "R6" : map_tag(1'b1, i, "R6"), "R9");
    // R7: writes to index 31 discarded in both modes
    cyc(1'b0, 1'b1, 31, 64'hFFFF_FFFF_FFFF_FFFF, 31, 30, "R7", "R9");
    cyc(1'b1, 1'b1, 31, 64'hDEAD_BEEF_0000_0001, 31, 25, "R7", "R4");
    cyc(1'b0, 1'b0, 0, '0, 31, 31, "R7", "R7");
    cyc(1'b1, 1'b0, 0, '0, 31, 31, "R7", "R7");
    // R9: mixed pseudo-random traffic
    lfsr = 64'h1234_5678_9ABC_DEF1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      cyc(lfsr[0], lfsr[1], int'(lfsr[10:6]), {lfsr[31:0], lfsr[63:32]},
          int'(lfsr[15:11]), int'(lfsr[20:16]), "R9", "R9");
    end
    // R1: second reset clears both banks
    do_reset();
    sweep_read(1'b0, "R1");
    sweep_read(1'b1, "R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4ns * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule